// File: doc/BRIEF.md
# Command Mailbox Responder (Device Side)

This block is the device end of a memory-mapped mailbox through which a host issues commands and collects reply data in chunks. The host sees a small window of 32-bit registers: a command word carrying opcode and queue index, a control/status word carrying the chunk length and handshake flags, a reserved word, and a read-only window of reply words. The device's own logic sees a one-cycle command strobe. It answers by filling the reply window through a fill port and then posting chunks through a post port, each with a length, a last flag and an error code.

Two handshakes are supported. In the normal mode each posted chunk raises a ready flag that the host must clear before the next chunk can be posted. A command issued with a requested size of zero is a payload-free command: its reply is a zero-length chunk carrying only an error code. The host must acknowledge it before the command word is cleared. A data command finishes on its own the cycle after its final chunk or an error is shown. In the legacy mode only the command word is used, and any post from the device clears it.

Top module: `mbx_responder`

## Requirements
- R1: After reset the command word, the control word, the reserved word and every reply word read 0, and `src_ready` and `cmd_valid` are low.
- R2: Host read decode by word address: 0 returns the command word (opcode in 15:0, queue index in 31:16); 1 returns the control word (chunk length 15:0, busy flag bit 16, chunk-ready bit 17, error code 27:18, bits 31:28 always 0); 2 returns 0; 3+i returns reply word i. Host writes to address 2 and to the reply window are ignored.
- R3: While no command is active, a host write to the control word loads the chunk length field from bits 15:0 (the requested size) and clears busy, chunk-ready and the error code.
- R4: In normal mode, a nonzero host write to the command word while idle stores it and sets busy. For exactly one cycle it raises `cmd_valid` with the opcode, the queue index and the requested size. A write of 0 while idle has no effect.
- R5: `src_ready` is high only while a command is active and no chunk is pending. A post sets chunk-ready, loads the error code and sets the chunk length to the smaller of `src_len` and DEPTH. Busy stays set unless the post is last or carries a nonzero error.
- R6: While a chunk is pending, a host control write with bit 17 clear removes chunk-ready and lets the next chunk be posted. A control write with bit 17 set changes nothing.
- R7: For a data command (requested size nonzero), a final chunk or a nonzero error clears busy, and the command word reads 0 one cycle later with no host acknowledge. Chunk-ready stays set.
- R8: For a payload-free command (requested size 0), the final chunk stays pending with the command word unchanged until the host clears chunk-ready. The command word clears on that same edge.
- R9: In legacy mode a nonzero command write raises `cmd_valid` and leaves the control word untouched. The next post clears the command word.
- R10: Host writes to the command word while a command is active are ignored.
- R11: A fill write with `fill_idx` below DEPTH updates that reply word. A fill index at or above DEPTH changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | Selects the single-register handshake |
| host_addr | input | ADDR_W | Host word address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_opcode | output | 16 | Opcode of the accepted command |
| cmd_qidx | output | 16 | Queue index of the accepted command |
| cmd_words | output | 16 | Requested reply size in words |
| src_ready | output | 1 | A chunk (or legacy acknowledge) may be posted |
| src_post | input | 1 | Post a chunk |
| src_len | input | 16 | Chunk length in words |
| src_last | input | 1 | Chunk is the final one |
| src_err | input | 10 | Error code for the chunk |
| fill_we | input | 1 | Reply window write strobe |
| fill_idx | input | FILL_W | Reply window word index |
| fill_data | input | 32 | Reply word value |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=4 and FILL_W=3. That makes the whole address space, including unmapped addresses 7 to 15, readable in one sweep. The 3-bit fill index reaches four indices beyond the window, so out-of-range fills can be checked. Chunk lengths from 0 to 6 then cover lengths below, at and above the cap. The bench also walks multi-chunk, error, payload-free and legacy transactions. Each expected word is computed from the field layout.

// File: rtl/mbx_pkg.sv
// Package: shared field layout, addresses and state encoding of the
// command mailbox responder. Assumes a 32-bit host data path.
package mbx_pkg;

    localparam int unsigned ADR_OP   = 0;
    localparam int unsigned ADR_CTRL = 1;
    localparam int unsigned ADR_RSV  = 2;
    localparam int unsigned ADR_WIN  = 3;

    localparam int unsigned RDY_BIT  = 17;

    // Control word; the first member sits in the top bits.
    typedef struct packed {
        logic [3:0]  rsvd;
        logic [9:0]  err;
        logic        rdy;
        logic        busy;
        logic [15:0] len;
    } mbx_ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_WAIT,
        ST_CLOSE,
        ST_LEGACY
    } mbx_state_e;

    // Clamp a requested chunk length to the window depth.
    function automatic logic [15:0] cap_len(input logic [15:0] len,
                                            input logic [15:0] depth);
        return (len > depth) ? depth : len;
    endfunction

endpackage

// File: rtl/mbx_window.sv
// Module: reply word storage. The device side writes one word per cycle;
// the host side only reads. Assumes DEPTH >= 1; out-of-range indices drop.
module mbx_window #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned FILL_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fill_we,
    input  logic [FILL_W-1:0]      fill_idx,
    input  logic [31:0]            fill_data,
    output logic [DEPTH-1:0][31:0] words
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        // Hold reply word i; load it when the fill index selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '0;
            else if (fill_we && (fill_idx == FILL_W'(i)))
                words[i] <= fill_data;
        end
    end

endmodule

// File: rtl/mbx_readmux.sv
// Module: host read decode. Pure combinational; unmapped addresses and the
// reserved word read as 0. Assumes ADDR_W reaches ADR_WIN+DEPTH-1.
module mbx_readmux
    import mbx_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            op_word,
    input  mbx_ctrl_t              ctrl_word,
    input  logic [DEPTH-1:0][31:0] words,
    output logic [31:0]            rdata
);

    // Select the word addressed by the host.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADR_OP))
            rdata = op_word;
        else if (addr == ADDR_W'(ADR_CTRL))
            rdata = ctrl_word;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (addr == ADDR_W'(ADR_WIN + i))
                rdata = words[i];
        end
    end

endmodule

// File: rtl/mbx_seq.sv
// Module: handshake sequencer. Owns the command and control words and runs
// the busy / chunk-ready / completion protocol in normal and legacy modes.
// Assumes the device posts only while src_ready is high.
module mbx_seq
    import mbx_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              legacy_mode,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [31:0]       host_wdata,
    input  logic              src_post,
    input  logic [15:0]       src_len,
    input  logic              src_last,
    input  logic [9:0]        src_err,
    output logic [31:0]       op_q,
    output mbx_ctrl_t         ctrl_q,
    output logic              src_ready,
    output logic              cmd_valid,
    output logic [15:0]       cmd_opcode,
    output logic [15:0]       cmd_qidx,
    output logic [15:0]       cmd_words
);

    localparam logic [15:0] DEPTH16 = 16'(DEPTH);

    mbx_state_e state_q;
    logic       nopay_q;
    logic       final_q;
    logic       wr_op;
    logic       wr_ctrl;
    logic       post_final;

    // Decode host write targets and whether a post ends the reply.
    always_comb begin
        wr_op      = host_we && (host_addr == ADDR_W'(ADR_OP));
        wr_ctrl    = host_we && (host_addr == ADDR_W'(ADR_CTRL));
        post_final = src_last || (src_err != '0);
        src_ready  = (state_q == ST_ACTIVE) || (state_q == ST_LEGACY);
    end

    // Advance the handshake and update the host-visible words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= '0;
            ctrl_q     <= '0;
            nopay_q    <= 1'b0;
            final_q    <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
            cmd_qidx   <= '0;
            cmd_words  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (wr_ctrl)
                        ctrl_q <= mbx_ctrl_t'({16'd0, host_wdata[15:0]});
                    if (wr_op && (host_wdata != '0)) begin
                        op_q       <= host_wdata;
                        cmd_valid  <= 1'b1;
                        cmd_opcode <= host_wdata[15:0];
                        cmd_qidx   <= host_wdata[31:16];
                        cmd_words  <= ctrl_q.len;
                        final_q    <= 1'b0;
                        if (legacy_mode) begin
                            state_q <= ST_LEGACY;
                        end else begin
                            state_q     <= ST_ACTIVE;
                            ctrl_q.busy <= 1'b1;
                            nopay_q     <= (ctrl_q.len == '0);
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (src_post) begin
                        ctrl_q.len  <= cap_len(src_len, DEPTH16);
                        ctrl_q.rdy  <= 1'b1;
                        ctrl_q.err  <= src_err;
                        ctrl_q.busy <= !post_final;
                        final_q     <= post_final;
                        if (post_final && !nopay_q)
                            state_q <= ST_CLOSE;
                        else
                            state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wr_ctrl && !host_wdata[RDY_BIT]) begin
                        ctrl_q.rdy <= 1'b0;
                        if (final_q) begin
                            op_q    <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_ACTIVE;
                        end
                    end
                end
                ST_CLOSE: begin
                    op_q    <= '0;
                    state_q <= ST_IDLE;
                end
                ST_LEGACY: begin
                    if (src_post) begin
                        op_q    <= '0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mbx_responder.sv
// Module: top of the command mailbox responder. Joins the sequencer, the
// reply window and the host read decode. Assumes ADDR_W covers 3+DEPTH-1
// and FILL_W can index DEPTH words.
module mbx_responder
    import mbx_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned FILL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              legacy_mode,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              cmd_valid,
    output logic [15:0]       cmd_opcode,
    output logic [15:0]       cmd_qidx,
    output logic [15:0]       cmd_words,
    output logic              src_ready,
    input  logic              src_post,
    input  logic [15:0]       src_len,
    input  logic              src_last,
    input  logic [9:0]        src_err,
    input  logic              fill_we,
    input  logic [FILL_W-1:0] fill_idx,
    input  logic [31:0]       fill_data
);

    logic [31:0]            op_q;
    mbx_ctrl_t              ctrl_q;
    logic [DEPTH-1:0][31:0] words;

    mbx_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .legacy_mode (legacy_mode),
        .host_addr   (host_addr),
        .host_we     (host_we),
        .host_wdata  (host_wdata),
        .src_post    (src_post),
        .src_len     (src_len),
        .src_last    (src_last),
        .src_err     (src_err),
        .op_q        (op_q),
        .ctrl_q      (ctrl_q),
        .src_ready   (src_ready),
        .cmd_valid   (cmd_valid),
        .cmd_opcode  (cmd_opcode),
        .cmd_qidx    (cmd_qidx),
        .cmd_words   (cmd_words)
    );

    mbx_window #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_we   (fill_we),
        .fill_idx  (fill_idx),
        .fill_data (fill_data),
        .words     (words)
    );

    mbx_readmux #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd (
        .addr      (host_addr),
        .op_word   (op_q),
        .ctrl_word (ctrl_q),
        .words     (words),
        .rdata     (host_rdata)
    );

endmodule

// File: rtl/mbx_responder_chk.sv
// Module: protocol checker for mbx_responder, attached by bind below.
module mbx_responder_chk #(
    parameter int unsigned DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] op_q,
    input logic [31:0] ctrl_q,
    input logic        src_ready,
    input logic        cmd_valid,
    input logic [15:0] cmd_opcode
);

    p_cmd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_cmd_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (op_q != 0) && (cmd_opcode == op_q[15:0]));

    p_op_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(op_q) != 0) && (op_q != 0)) |-> (op_q == $past(op_q)));

    p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[17] |-> (ctrl_q[15:0] <= 16'(DEPTH)));

    p_ready_needs_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (op_q != 0));

    p_err_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[17] && (ctrl_q[27:18] != 0)) |-> !ctrl_q[16]);

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[31:28] == 4'd0);

endmodule

bind mbx_responder mbx_responder_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_q       (op_q),
    .ctrl_q     (ctrl_q),
    .src_ready  (src_ready),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode)
);

// File: tb/mbx_responder_test.sv
module mbx_responder_test;

    localparam int unsigned DEPTH  = 4;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned FILL_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              legacy_mode = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic              host_we = 1'b0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              cmd_valid;
    logic [15:0]       cmd_opcode, cmd_qidx, cmd_words;
    logic              src_ready;
    logic              src_post = 1'b0;
    logic [15:0]       src_len = '0;
    logic              src_last = 1'b0;
    logic [9:0]        src_err = '0;
    logic              fill_we = 1'b0;
    logic [FILL_W-1:0] fill_idx = '0;
    logic [31:0]       fill_data = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mbx_responder #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .FILL_W(FILL_W)) uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input logic [9:0] err, input logic rdy,
                                              input logic busy, input logic [15:0] len);
        return {4'd0, err, rdy, busy, len};
    endfunction

    task automatic rd(input int a, output logic [31:0] d);
        host_addr = ADDR_W'(a);
        #1 d = host_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        host_addr = ADDR_W'(a); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic post(input int len, input logic last, input logic [9:0] err);
        @(negedge clk);
        src_post = 1'b1; src_len = 16'(len); src_last = last; src_err = err;
        @(negedge clk);
        src_post = 1'b0;
    endtask

    task automatic fill(input int idx, input logic [31:0] d);
        @(negedge clk);
        fill_we = 1'b1; fill_idx = FILL_W'(idx); fill_data = d;
        @(negedge clk);
        fill_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state across the whole address space (R2 decode of unmapped)
        for (int a = 0; a < 16; a++) begin
            rd(a, v); check($sformatf("R1 addr %0d", a), v, 0);
        end
        check("R1 src_ready", {31'd0, src_ready}, 0);
        check("R1 cmd_valid", {31'd0, cmd_valid}, 0);

        // R11: fill window, out-of-range indices ignored; R2 window decode
        for (int i = 0; i < 8; i++) fill(i, 32'hC0DE_0000 + 32'(i));
        for (int i = 0; i < DEPTH; i++) begin
            rd(3 + i, v); check("R11 fill word", v, 32'hC0DE_0000 + 32'(i));
        end
        for (int a = 3 + DEPTH; a < 16; a++) begin
            rd(a, v); check("R2 unmapped", v, 0);
        end
        // R2: writes to reserved word and window ignored
        wr(2, 32'hFFFF_FFFF); rd(2, v); check("R2 reserved", v, 0);
        wr(3, 32'h1234_5678); rd(3, v); check("R2 window ro", v, 32'hC0DE_0000);

        // R3: idle control write loads length, clears flags
        wr(1, 32'hFFFF_0009); rd(1, v); check("R3 ctrl load", v, ctrl_word(0, 0, 0, 9));
        // R4: zero opcode write when idle has no effect
        wr(0, 0); rd(0, v); check("R4 zero op", v, 0);
        check("R4 zero op strobe", {31'd0, cmd_valid}, 0);

        // R4/R5/R7: sweep chunk lengths across the cap, single final chunk
        for (int n = 0; n <= 6; n++) begin
            wr(1, 32'd8);
            wr(0, {16'(n + 1), 16'd2});
            check("R4 strobe", {31'd0, cmd_valid}, 1);
            check("R4 opcode", {16'd0, cmd_opcode}, 2);
            check("R4 qidx", {16'd0, cmd_qidx}, 32'(n + 1));
            check("R4 words", {16'd0, cmd_words}, 8);
            rd(1, v); check("R4 busy", v, ctrl_word(0, 0, 1, 8));
            @(negedge clk);
            check("R4 strobe drop", {31'd0, cmd_valid}, 0);
            check("R5 ready", {31'd0, src_ready}, 1);
            for (int i = 0; i < DEPTH; i++) fill(i, 32'hA000_0000 + 32'(n * 16 + i));
            post(n, 1'b1, 0);
            rd(1, v); check("R5 R7 final chunk", v, ctrl_word(0, 1, 0, 16'((n > DEPTH) ? DEPTH : n)));
            rd(0, v); check("R7 op before close", v, {16'(n + 1), 16'd2});
            check("R5 not ready", {31'd0, src_ready}, 0);
            @(negedge clk);
            rd(0, v); check("R7 op cleared", v, 0);
            for (int i = 0; i < DEPTH; i++) begin
                rd(3 + i, v); check("R11 window", v, 32'hA000_0000 + 32'(n * 16 + i));
            end
        end

        // R6/R10: multi-chunk transfer
        wr(1, 32'd6);
        wr(0, {16'd7, 16'd2});
        post(3, 1'b0, 0);
        rd(1, v); check("R5 mid chunk", v, ctrl_word(0, 1, 1, 3));
        wr(0, {16'd1, 16'd4}); rd(0, v); check("R10 op write ignored", v, {16'd7, 16'd2});
        wr(1, ctrl_word(0, 1, 1, 3));
        rd(1, v); check("R6 rdy kept", v, ctrl_word(0, 1, 1, 3));
        check("R6 no ready", {31'd0, src_ready}, 0);
        wr(1, ctrl_word(0, 0, 1, 3));
        rd(1, v); check("R6 rdy cleared", v, ctrl_word(0, 0, 1, 3));
        check("R6 ready again", {31'd0, src_ready}, 1);
        post(2, 1'b1, 0);
        rd(1, v); check("R7 last chunk", v, ctrl_word(0, 1, 0, 2));
        @(negedge clk); rd(0, v); check("R7 closed", v, 0);

        // R7: error ends a data command
        wr(1, 32'd4);
        wr(0, {16'd2, 16'd2});
        post(2, 1'b0, 10'd7);
        rd(1, v); check("R7 error chunk", v, ctrl_word(10'd7, 1, 0, 2));
        @(negedge clk); rd(0, v); check("R7 error closes", v, 0);

        // R8: payload-free command held until acknowledge
        wr(1, 32'd0);
        wr(0, {16'd0, 16'd3});
        check("R8 words zero", {16'd0, cmd_words}, 0);
        post(0, 1'b1, 10'd5);
        rd(1, v); check("R8 ack chunk", v, ctrl_word(10'd5, 1, 0, 0));
        repeat (3) @(negedge clk);
        rd(0, v); check("R8 op held", v, {16'd0, 16'd3});
        @(negedge clk);
        host_addr = ADDR_W'(1); host_wdata = ctrl_word(10'd5, 0, 0, 0); host_we = 1'b1;
        @(negedge clk); host_we = 1'b0;
        rd(0, v); check("R8 op cleared on ack", v, 0);
        rd(1, v); check("R8 ctrl after ack", v, ctrl_word(10'd5, 0, 0, 0));

        // R9: legacy single-register handshake
        legacy_mode = 1'b1;
        wr(1, 32'd3);
        wr(0, 32'd1);
        check("R9 strobe", {31'd0, cmd_valid}, 1);
        rd(1, v); check("R9 ctrl untouched", v, ctrl_word(0, 0, 0, 3));
        rd(0, v); check("R9 op stored", v, 1);
        check("R9 ready", {31'd0, src_ready}, 1);
        wr(0, 32'd4); rd(0, v); check("R10 legacy op ignored", v, 1);
        post(0, 1'b0, 0);
        rd(0, v); check("R9 op cleared", v, 0);
        rd(1, v); check("R9 ctrl still", v, ctrl_word(0, 0, 0, 3));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule